// File: doc/BRIEF.md
# Boot Jump Injector

After a reset, a processor fetches its first instruction from wherever its program counter points, normally address zero. This block intercepts the first three memory reads after a reset and answers them itself: a jump opcode, then the low byte of a target address, then a high byte set on a bank of switches. The processor therefore begins execution at the selected address, for example a monitor in read-only memory, without any code at location zero.

A reset can come from a power-on clear or from a momentary start button. Both reach the block as one synchronous reset input. The block counts read strobes by detecting their edges in the system clock domain. While it is injecting bytes, it keeps the on-board memory decode inhibited so that no memory drives the data-in bus at the same time. The same inhibit is also raised for every I/O or interrupt-acknowledge cycle. Once the third byte has been delivered, the block is idle and stays out of the way until the next reset.

Top module: `boot_jam_seq`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it is sampled high, the outputs are `mem_inhibit_o`=1, `jam_en_o`=0 and `jam_byte_o`=0xC3. The sequencer restarts from its first byte.
- R2: During the first read after reset, `jam_en_o` is 1 from one clock after `rd_strobe_i` rises until one clock after it falls, and `jam_byte_o` is 0xC3 (jump opcode).
- R3: During the second read, `jam_byte_o` is the fixed low address byte, 0x00 by default.
- R4: During the third read, `jam_byte_o` equals the value on `start_sw_i`.
- R5: After the trailing edge of the third read strobe, `jam_en_o` stays 0 and `jam_byte_o` stays 0x00 for every later read until the next reset.
- R6: `mem_inhibit_o` is 1 from reset until one clock after the trailing edge of the third read strobe. After that it equals the value `io_cyc_i | int_cyc_i` had one clock earlier.
- R7: A read strobe held high for any number of clocks advances the sequence by exactly one byte, and it does so on its trailing edge.
- R8: The switch value is used live. A change on `start_sw_i` before the third read shows in that read's byte one clock later.
- R9: A reset in the middle of the sequence restarts it, so the next read again receives 0xC3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high bus reset (power-on or start button) |
| rd_strobe_i | input | 1 | Processor data-in read strobe, synchronous to clk_i |
| io_cyc_i | input | 1 | Current machine cycle is an I/O cycle |
| int_cyc_i | input | 1 | Current machine cycle is an interrupt acknowledge |
| start_sw_i | input | 8 | Switch word giving the high byte of the start address |
| jam_byte_o | output | 8 | Byte to place on the data-in bus |
| jam_en_o | output | 1 | Drive jam_byte_o onto the data-in bus |
| mem_inhibit_o | output | 1 | Block the RAM/PROM address decode |

## Verification
The condition that is hardest to reach from the ports is a read strobe that stays high for a long time. It must move the sequence by one byte, and the third byte must reflect a switch change made just before that read. The stimulus stretches one strobe over twenty clocks and changes the switches between reads. It also asserts reset in the middle of a sequence, to confirm the restart. After completion it mixes I/O and interrupt cycles with ordinary reads, to confirm that the inhibit then follows the cycle type alone.

// File: rtl/boot_jam_pkg.sv
package boot_jam_pkg;
  // Sequence codes; the order is the stepping order of the injector.
  typedef enum logic [2:0] {
    JS_OPCODE = 3'b000,
    JS_ADDR_LO = 3'b111,
    JS_ADDR_HI = 3'b010,
    JS_IDLE = 3'b001
  } jam_state_t;
endpackage

// File: rtl/boot_strobe_edge.sv
module boot_strobe_edge #(
  parameter bit STEP_ON_TRAIL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic step_o
);
  logic strobe_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) strobe_q <= 1'b0;
    else       strobe_q <= strobe_i;
  end

  generate
    if (STEP_ON_TRAIL) begin : g_trail
      assign step_o = strobe_q & ~strobe_i;
    end else begin : g_lead
      assign step_o = ~strobe_q & strobe_i;
    end
  endgenerate
endmodule

// File: rtl/boot_jam_fsm.sv
module boot_jam_fsm
  import boot_jam_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       step_i,
  output jam_state_t state_o,
  output logic       busy_o
);
  jam_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step_i) begin
      case (state_q)
        JS_OPCODE:  state_d = JS_ADDR_LO;
        JS_ADDR_LO: state_d = JS_ADDR_HI;
        JS_ADDR_HI: state_d = JS_IDLE;
        default:    state_d = JS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= JS_OPCODE;
    else       state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != JS_IDLE);
endmodule

// File: rtl/boot_jam_mux.sv
module boot_jam_mux
  import boot_jam_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] OPCODE  = 8'hC3,
  parameter logic [DATA_W-1:0] LO_BYTE = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  jam_state_t        state_i,
  input  logic              busy_i,
  input  logic              rd_strobe_i,
  input  logic              io_cyc_i,
  input  logic              int_cyc_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              en_o,
  output logic              inhibit_o
);
  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    case (state_i)
      JS_OPCODE:  sel_byte = OPCODE;
      JS_ADDR_LO: sel_byte = LO_BYTE;
      JS_ADDR_HI: sel_byte = sw_i;
      default:    sel_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      byte_o    <= OPCODE;
      en_o      <= 1'b0;
      inhibit_o <= 1'b1;
    end else begin
      byte_o    <= sel_byte;
      en_o      <= busy_i & rd_strobe_i;
      inhibit_o <= busy_i | io_cyc_i | int_cyc_i;
    end
  end
endmodule

// File: rtl/boot_jam_seq.sv
module boot_jam_seq
  import boot_jam_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter logic [DATA_W-1:0] OPCODE        = 8'hC3,
  parameter logic [DATA_W-1:0] LO_BYTE       = 8'h00,
  parameter bit                STEP_ON_TRAIL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_strobe_i,
  input  logic              io_cyc_i,
  input  logic              int_cyc_i,
  input  logic [DATA_W-1:0] start_sw_i,
  output logic [DATA_W-1:0] jam_byte_o,
  output logic              jam_en_o,
  output logic              mem_inhibit_o
);
  logic       step;
  logic       busy;
  jam_state_t state;

  boot_strobe_edge #(.STEP_ON_TRAIL(STEP_ON_TRAIL)) u_edge (
    .clk_i(clk_i), .rst_i(rst_i), .strobe_i(rd_strobe_i), .step_o(step)
  );

  boot_jam_fsm u_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(step), .state_o(state), .busy_o(busy)
  );

  boot_jam_mux #(.DATA_W(DATA_W), .OPCODE(OPCODE), .LO_BYTE(LO_BYTE)) u_mux (
    .clk_i(clk_i), .rst_i(rst_i), .state_i(state), .busy_i(busy),
    .rd_strobe_i(rd_strobe_i), .io_cyc_i(io_cyc_i), .int_cyc_i(int_cyc_i),
    .sw_i(start_sw_i), .byte_o(jam_byte_o), .en_o(jam_en_o),
    .inhibit_o(mem_inhibit_o)
  );
endmodule

// File: rtl/boot_jam_chk.sv
module boot_jam_chk #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] OPCODE = 8'hC3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              rd_strobe_i,
  input logic              io_cyc_i,
  input logic              int_cyc_i,
  input logic [DATA_W-1:0] jam_byte_o,
  input logic              jam_en_o,
  input logic              mem_inhibit_o
);
  assert_reset_state_R1: assert property (@(posedge clk_i)
    rst_i |=> (mem_inhibit_o && !jam_en_o && jam_byte_o == OPCODE));

  assert_en_follows_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    jam_en_o |-> $past(rd_strobe_i));

  assert_en_implies_inhibit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    jam_en_o |-> mem_inhibit_o);

  assert_cycle_type_inhibit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (io_cyc_i || int_cyc_i) |=> mem_inhibit_o);

  assert_idle_byte_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !mem_inhibit_o |-> (jam_byte_o == '0));

  assert_idle_no_drive_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !mem_inhibit_o |=> !jam_en_o);
endmodule

bind boot_jam_seq boot_jam_chk #(.DATA_W(DATA_W), .OPCODE(OPCODE)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .rd_strobe_i(rd_strobe_i), .io_cyc_i(io_cyc_i),
  .int_cyc_i(int_cyc_i), .jam_byte_o(jam_byte_o), .jam_en_o(jam_en_o),
  .mem_inhibit_o(mem_inhibit_o)
);

// File: tb/sim_boot_jam_seq.sv
`timescale 1ns/1ps
module sim_boot_jam_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd = 1'b0;
  logic       io = 1'b0;
  logic       intr = 1'b0;
  logic [7:0] sw = 8'hFD;
  logic [7:0] jam_byte;
  logic       jam_en;
  logic       inhibit;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string req = "R1";

  // behavioural reference: how many bytes have been handed over so far
  int       served = 0;
  bit       rd_prev = 0;
  logic [7:0] exp_byte = 8'hC3;
  bit       exp_en = 0;
  bit       exp_inh = 1;

  always #4 clk = ~clk;

  boot_jam_seq u0 (
    .clk_i(clk), .rst_i(rst), .rd_strobe_i(rd), .io_cyc_i(io), .int_cyc_i(intr),
    .start_sw_i(sw), .jam_byte_o(jam_byte), .jam_en_o(jam_en), .mem_inhibit_o(inhibit)
  );

  always @(posedge clk) begin
    if (rst) begin
      served = 0; rd_prev = 0;
      exp_byte = 8'hC3; exp_en = 0; exp_inh = 1;
    end else begin
      exp_en  = (served < 3) && rd;
      exp_inh = (served < 3) || io || intr;
      if (served == 0)      exp_byte = 8'hC3;
      else if (served == 1) exp_byte = 8'h00;
      else if (served == 2) exp_byte = sw;
      else                  exp_byte = 8'h00;
      if (rd_prev && !rd && served < 3) served++;
      rd_prev = rd;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (jam_byte !== exp_byte || jam_en !== exp_en || inhibit !== exp_inh) begin
        errors++;
        $display("FAIL %s: byte=%h en=%b inh=%b expected byte=%h en=%b inh=%b",
                 req, jam_byte, jam_en, inhibit, exp_byte, exp_en, exp_inh);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one read of given length; checks the delivered byte mid-strobe
  task automatic fetch(input int hold, input logic [7:0] want, input bit want_en, input string tag);
    @(negedge clk); rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (jam_byte !== want || jam_en !== want_en) begin
      errors++;
      $display("FAIL %s: fetch byte=%h en=%b expected byte=%h en=%b", tag, jam_byte, jam_en, want, want_en);
    end
    for (int i = 2; i < hold; i++) @(negedge clk);
    rd = 1'b0;
    idle(3);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk); rst = 1'b1;
    idle(n);
    rst = 1'b0;
  endtask

  initial begin
    req = "R1";
    idle(3);
    rst = 1'b0;
    checks++;
    if (inhibit !== 1'b1 || jam_en !== 1'b0 || jam_byte !== 8'hC3) begin
      errors++;
      $display("FAIL R1: reset state inh=%b en=%b byte=%h expected 1 0 c3", inhibit, jam_en, jam_byte);
    end
    req = "R6"; io = 1'b1; idle(2); io = 1'b0; intr = 1'b1; idle(2); intr = 1'b0; idle(2);
    req = "R2"; fetch(4, 8'hC3, 1'b1, "R2");
    req = "R7"; fetch(20, 8'h00, 1'b1, "R3 R7");
    req = "R8"; sw = 8'hA5; idle(2);
    req = "R4"; fetch(3, 8'hA5, 1'b1, "R4 R8");
    req = "R5"; fetch(4, 8'h00, 1'b0, "R5");
    req = "R6"; io = 1'b1; fetch(3, 8'h00, 1'b0, "R6"); io = 1'b0; idle(2);
    checks++;
    if (inhibit !== 1'b0) begin
      errors++;
      $display("FAIL R6: inhibit after done=%b expected 0", inhibit);
    end
    intr = 1'b1; idle(1); intr = 1'b0; idle(3);
    req = "R9"; do_reset(2);
    fetch(3, 8'hC3, 1'b1, "R9");
    do_reset(1);
    fetch(5, 8'hC3, 1'b1, "R9");
    sw = 8'hFF;
    fetch(2, 8'h00, 1'b1, "R3");
    fetch(6, 8'hFF, 1'b1, "R4");
    fetch(3, 8'h00, 1'b0, "R5");
    idle(4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule